// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block schedules and runs the periodic all-bank refresh for one memory rank. It tracks the time at which the next refresh is due. Shortly before that time it takes the rank away from the command scheduler. It then waits for in-flight accesses to finish and wakes the rank if it was in a low-power state. Next it closes any open banks with one precharge-all command and issues a single all-bank refresh. When the refresh is done it hands the rank back.

Time is supplied as a free-running cycle count on `now_cyc`. The command scheduler supplies three inputs:

- how many banks are open;
- the latest time at which every bank may legally be precharged;
- whether commands to the rank are still in flight.

The power manager reports the rank's current low-power mode. The sequencer returns three things:

- one-cycle command strobes;
- a time before which no bank may be activated;
- a request telling the power manager which low-power mode to re-enter once the refresh is over.

Power-mode encoding, used on `lp_mode` and `lp_enter_mode`:

| Code | Mode |
|------|------|
| 0 | awake |
| 1 | active power-down |
| 2 | precharge power-down |
| 3 | self-refresh |

Top module: `rank_refresh_seq`

## Requirements
- R1: After reset, `rank_avail` is 1, all strobes and `overrun` are 0, `act_ok_at` is 0, and the first refresh is due at time TREFI.
- R2: A sequence begins on the first clock edge at which `now_cyc` >= due − TRP. `rank_avail` drops to 0 in the following cycle.
- R3: While `rank_busy` is 1 after a sequence has begun, no command strobe is issued and `rank_avail` stays 0.
- R4: The power mode is sampled when the sequence begins. If it is non-zero, `pup_stb` pulses once after draining. Code 3 is followed by a wait of TXS cycles before any precharge or refresh. Codes 1 and 2 are followed by a wait of TXP cycles.
- R5: If `open_banks` is non-zero, one `prea_stb` is issued on the first edge at which `now_cyc` >= `pre_ok_at`. `act_ok_at` then becomes that time plus TRP.
- R6: If `open_banks` is 0 when the precharge step is reached, no `prea_stb` is issued and the refresh follows directly.
- R7: `ref_stb` is issued no earlier than TRP after the precharge. `act_ok_at` becomes the refresh time plus TRFC. `rank_avail` returns to 1 on the first edge at which `now_cyc` reaches that completion time.
- R8: Each refresh advances the due time by TREFI, so the next sequence starts TRP before the new due time.
- R9: `overrun` is set, and stays set until reset, when the advanced due time is earlier than the completion time of the refresh just issued.
- R10: On release, `lp_enter_stb` pulses with the sampled mode if that mode was 2 or 3. Otherwise it pulses with mode 2 if `rank_busy` is 0, and does not pulse if `rank_busy` is 1.
- R11: At most one of `prea_stb`, `ref_stb` and `pup_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_cyc | input | TW | Current cycle count |
| open_banks | input | BW | Number of banks currently open in the rank |
| pre_ok_at | input | TW | Latest precharge-allowed time across banks |
| lp_mode | input | 2 | Current low-power mode of the rank |
| rank_busy | input | 1 | Commands to the rank still in flight |
| prea_stb | output | 1 | Precharge-all command strobe |
| ref_stb | output | 1 | All-bank refresh command strobe |
| pup_stb | output | 1 | Power-up (low-power exit) command strobe |
| lp_enter_stb | output | 1 | Request to enter a low-power mode after refresh |
| lp_enter_mode | output | 2 | Mode requested by `lp_enter_stb` |
| rank_avail | output | 1 | Rank may be used by the scheduler |
| act_ok_at | output | TW | Earliest activate time for every bank |
| overrun | output | 1 | Sticky refresh overrun error |

## Verification
The assertions assume that `now_cyc` advances by exactly one on every clock after reset. They also assume that `pre_ok_at` and `open_banks` describe the rank faithfully, so a precharge is only checked against the values seen on the edge where it was issued. The stimulus derives every input from the current value of `now_cyc` in fixed windows. A sequence therefore always sees consistent inputs, whether the rank is drained, asleep, idle or holding open banks. The one deliberate stretch of `rank_busy` is long enough to force an overrun.

// File: rtl/rank_refresh_seq.sv
module rank_refresh_seq #(
  parameter int TW    = 32,
  parameter int BW    = 4,
  parameter int TRP   = 4,
  parameter int TRFC  = 20,
  parameter int TREFI = 200,
  parameter int TXP   = 3,
  parameter int TXS   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_cyc,
  input  logic [BW-1:0] open_banks,
  input  logic [TW-1:0] pre_ok_at,
  input  logic [1:0]    lp_mode,
  input  logic          rank_busy,
  output logic          prea_stb,
  output logic          ref_stb,
  output logic          pup_stb,
  output logic          lp_enter_stb,
  output logic [1:0]    lp_enter_mode,
  output logic          rank_avail,
  output logic [TW-1:0] act_ok_at,
  output logic          overrun
);

  localparam logic [TW-1:0] TRP_W   = TW'(TRP);
  localparam logic [TW-1:0] TRFC_W  = TW'(TRFC);
  localparam logic [TW-1:0] TREFI_W = TW'(TREFI);
  localparam logic [TW-1:0] TXP_W   = TW'(TXP);
  localparam logic [TW-1:0] TXS_W   = TW'(TXS);

  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_WAKE, S_PRE, S_PREW, S_REF, S_RUN
  } st_t;

  st_t           st;
  logic [TW-1:0] due, tgt;
  logic [1:0]    saved;

  wire [TW-1:0] start_at = due - TRP_W;
  wire [TW-1:0] next_due = due + TREFI_W;
  wire [TW-1:0] ref_end  = now_cyc + TRFC_W;
  wire          reached  = now_cyc >= tgt;
  wire          keep_lp  = saved[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      due           <= TREFI_W;
      tgt           <= '0;
      saved         <= 2'd0;
      act_ok_at     <= '0;
      rank_avail    <= 1'b1;
      overrun       <= 1'b0;
      prea_stb      <= 1'b0;
      ref_stb       <= 1'b0;
      pup_stb       <= 1'b0;
      lp_enter_stb  <= 1'b0;
      lp_enter_mode <= 2'd0;
    end else begin
      prea_stb     <= 1'b0;
      ref_stb      <= 1'b0;
      pup_stb      <= 1'b0;
      lp_enter_stb <= 1'b0;
      case (st)
        S_IDLE: if (now_cyc >= start_at) begin
          st         <= S_DRAIN;
          rank_avail <= 1'b0;
          saved      <= lp_mode;
        end
        S_DRAIN: if (!rank_busy) begin
          if (saved != 2'd0) begin
            pup_stb <= 1'b1;
            tgt     <= now_cyc + ((saved == 2'd3) ? TXS_W : TXP_W);
            st      <= S_WAKE;
          end else begin
            st <= S_PRE;
          end
        end
        S_WAKE: if (reached) st <= S_PRE;
        S_PRE: begin
          if (open_banks == '0) begin
            st <= S_REF;
          end else if (now_cyc >= pre_ok_at) begin
            prea_stb  <= 1'b1;
            act_ok_at <= now_cyc + TRP_W;
            tgt       <= now_cyc + TRP_W;
            st        <= S_PREW;
          end
        end
        S_PREW: if (reached) st <= S_REF;
        S_REF: begin
          ref_stb   <= 1'b1;
          tgt       <= ref_end;
          act_ok_at <= ref_end;
          due       <= next_due;
          if (next_due < ref_end) overrun <= 1'b1;
          st        <= S_RUN;
        end
        S_RUN: if (reached) begin
          st         <= S_IDLE;
          rank_avail <= 1'b1;
          if (keep_lp) begin
            lp_enter_stb  <= 1'b1;
            lp_enter_mode <= saved;
          end else if (!rank_busy) begin
            lp_enter_stb  <= 1'b1;
            lp_enter_mode <= 2'd2;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cmd_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prea_stb, ref_stb, pup_stb}));

  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now_cyc == $past(now_cyc) + 1'b1);

  p_no_cmd_when_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prea_stb || ref_stb || pup_stb) |-> !rank_avail);

  p_prea_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prea_stb |-> ($past(now_cyc) >= $past(pre_ok_at)) && ($past(open_banks) != '0));

  p_release_after_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rank_avail) |-> $past(now_cyc) >= act_ok_at);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);

  p_lp_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter_stb |-> lp_enter_mode[1] && $rose(rank_avail));

endmodule

// File: tb/rank_refresh_seq_bench.sv
module rank_refresh_seq_bench;
  localparam int TW = 32, BW = 4;
  localparam int TRP = 4, TRFC = 20, TREFI = 200, TXP = 3, TXS = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] now_cyc = '0;
  logic [BW-1:0] open_banks = '0;
  logic [TW-1:0] pre_ok_at = '0;
  logic [1:0]    lp_mode = 2'd0;
  logic          rank_busy = 1'b0;
  logic          prea_stb, ref_stb, pup_stb, lp_enter_stb, rank_avail, overrun;
  logic [1:0]    lp_enter_mode;
  logic [TW-1:0] act_ok_at;

  rank_refresh_seq #(.TW(TW), .BW(BW), .TRP(TRP), .TRFC(TRFC), .TREFI(TREFI),
                     .TXP(TXP), .TXS(TXS)) u_rank_refresh_seq (
    .clk(clk), .rst_n(rst_n), .now_cyc(now_cyc), .open_banks(open_banks),
    .pre_ok_at(pre_ok_at), .lp_mode(lp_mode), .rank_busy(rank_busy),
    .prea_stb(prea_stb), .ref_stb(ref_stb), .pup_stb(pup_stb),
    .lp_enter_stb(lp_enter_stb), .lp_enter_mode(lp_enter_mode),
    .rank_avail(rank_avail), .act_ok_at(act_ok_at), .overrun(overrun));

  always #5 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  // reference model state
  longint m_due, m_tgt, m_act;
  int     m_ph, m_saved, m_lpm;
  bit     m_avail, m_prea, m_ref, m_pup, m_lps, m_ovr;
  int     n_prea_sleep = 0, n_ref_sleep = 0, n_pup = 0;
  longint first_fall = -1;

  task automatic chk(string req, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at now=%0d: actual %0d expected %0d", req, now_cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_due = TREFI; m_tgt = 0; m_act = 0; m_saved = 0; m_lpm = 0;
      m_avail = 1; m_ovr = 0; m_prea = 0; m_ref = 0; m_pup = 0; m_lps = 0;
    end else begin
      longint t;
      t = longint'(now_cyc);
      m_prea = 0; m_ref = 0; m_pup = 0; m_lps = 0;
      if (m_ph == 0) begin
        if (t >= m_due - TRP) begin m_ph = 1; m_avail = 0; m_saved = lp_mode; end
      end else if (m_ph == 1) begin
        if (!rank_busy) begin
          if (m_saved != 0) begin
            m_pup = 1; m_tgt = t + ((m_saved == 3) ? TXS : TXP); m_ph = 2;
          end else m_ph = 3;
        end
      end else if (m_ph == 2) begin
        if (t >= m_tgt) m_ph = 3;
      end else if (m_ph == 3) begin
        if (open_banks == 0) m_ph = 5;
        else if (t >= longint'(pre_ok_at)) begin
          m_prea = 1; m_act = t + TRP; m_tgt = t + TRP; m_ph = 4;
        end
      end else if (m_ph == 4) begin
        if (t >= m_tgt) m_ph = 5;
      end else if (m_ph == 5) begin
        m_ref = 1; m_tgt = t + TRFC; m_act = t + TRFC;
        if (m_due + TREFI < t + TRFC) m_ovr = 1;
        m_due = m_due + TREFI; m_ph = 6;
      end else begin
        if (t >= m_tgt) begin
          m_ph = 0; m_avail = 1;
          if (m_saved >= 2) begin m_lps = 1; m_lpm = m_saved; end
          else if (!rank_busy) begin m_lps = 1; m_lpm = 2; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 rank_avail", rank_avail, m_avail);
      chk("R5 prea_stb", prea_stb, m_prea);
      chk("R7 ref_stb", ref_stb, m_ref);
      chk("R7 act_ok_at", act_ok_at, m_act);
      chk("R4 pup_stb", pup_stb, m_pup);
      chk("R10 lp_enter_stb", lp_enter_stb, m_lps);
      if (m_lps) chk("R10 lp_enter_mode", lp_enter_mode, m_lpm);
      chk("R9 overrun", overrun, m_ovr);
      chk("R11 strobes onehot", $countones({prea_stb, ref_stb, pup_stb}) <= 1, 1);
      if (first_fall < 0 && !rank_avail) first_fall = longint'(now_cyc);
      if ((now_cyc >= 500 && now_cyc < 700) || (now_cyc >= 900 && now_cyc < 1100)) begin
        if (prea_stb) n_prea_sleep++;
        if (ref_stb) n_ref_sleep++;
      end
      if (pup_stb) n_pup++;
    end
  end

  task automatic drive_inputs();
    longint t;
    t = longint'(now_cyc);
    if (t < 300) begin
      open_banks = 3; pre_ok_at = 0; lp_mode = 0; rank_busy = 0;
    end else if (t < 500) begin
      open_banks = 1; pre_ok_at = 410; lp_mode = 0; rank_busy = (t < 420);
    end else if (t < 700) begin
      open_banks = 0; lp_mode = 1; rank_busy = 0;
    end else if (t < 900) begin
      open_banks = 2; pre_ok_at = 0; lp_mode = 3; rank_busy = 0;
    end else if (t < 1100) begin
      open_banks = 0; lp_mode = 2; rank_busy = 0;
    end else if (t < 1500) begin
      open_banks = 2; pre_ok_at = 0; lp_mode = 0; rank_busy = (t >= 1150 && t < 1420);
    end else begin
      open_banks = 1; pre_ok_at = 0; lp_mode = 0; rank_busy = (t % 3 == 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drive_inputs();
    @(negedge clk);
    // R1 reset state (before the first active edge after reset)
    chk("R1 rank_avail", rank_avail, 1);
    chk("R1 strobes", {prea_stb, ref_stb, pup_stb, lp_enter_stb}, 0);
    chk("R1 act_ok_at", act_ok_at, 0);
    chk("R1 overrun", overrun, 0);
    while (now_cyc < 1800) begin
      @(posedge clk);
      #1 now_cyc = now_cyc + 1;
      drive_inputs();
    end
    @(negedge clk);
    done = 1'b1;
    chk("R2 first sequence start", first_fall, TREFI - TRP + 1);
    chk("R6 no precharge with banks closed", n_prea_sleep, 0);
    chk("R6 refresh still issued", n_ref_sleep, 2);
    chk("R4 power-up count", n_pup, 3);
    chk("R9 overrun raised", overrun, 1);
    chk("R8 due advanced", m_due, 9 * TREFI);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule